// File: doc/BRIEF.md
# Circular Error Log with In-Array Wrap Marker

This block records error events in a fixed ring of 32 slots. Each slot holds a 32-bit error code together with a 32-bit timestamp. New events are written one per cycle through a push port. Once the ring is full, each new event overwrites the oldest one.

Software-facing logic above this block never needs a separate head pointer. The ring carries a one-hot wrap flag alongside its slots. The flagged slot is always the next slot to be written, which is also the oldest entry once the ring has filled. A read by logical index finds the flag and adds the index to its position, so entries come back oldest-first. Reading the slots in plain physical order would mix old and new entries.

Slots that have never been written hold all-ones, and a code of 0xFFFFFFFF is never reported as a real error. A separate output always shows the most recently pushed code and its timestamp.

Top module: `elog_ring_top`

## Requirements
- R1: After synchronous active-low reset, every logical index reads with valid low, and `last_valid` is low.
- R2: When `push_en` is high at a rising edge, `last_code` and `last_time` equal the pushed code and time from that edge onward.
- R3: After n pushes with n at most 32, logical index 32-n+k (for 0 <= k < n) returns the k-th push, counting the first push as k = 0.
- R4: After n pushes with n above 32, logical index i returns push number n-32+i. Index 0 is the oldest surviving entry and index 31 is the newest.
- R5: A logical index that maps to a slot never written returns code 0xFFFFFFFF, time 0xFFFFFFFF, and valid low.
- R6: A read is registered. When `rd_en` is high at a rising edge, `rd_code`, `rd_time` and `rd_valid` show the entry from that edge, and they hold while `rd_en` is low.
- R7: When a read and a push share a rising edge, the read returns the contents from before that push.
- R8: A pushed code of 0xFFFFFFFF is stored, but it is reported with valid low, both on the read port and on the last-error output.
- R9: Exactly one wrap flag is set at all times. Each push moves it forward by one slot, and it wraps from slot 31 to slot 0.
- R10: With `push_en` low, the flag position and the last-error outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_en | input | 1 | Record one event this cycle |
| push_code | input | 32 | Error code to record |
| push_time | input | 32 | Timestamp to record |
| rd_en | input | 1 | Sample a logical entry this cycle |
| rd_idx | input | 5 | Logical index, 0 = oldest |
| rd_code | output | 32 | Code of the sampled entry |
| rd_time | output | 32 | Timestamp of the sampled entry |
| rd_valid | output | 1 | Sampled entry holds a real error |
| last_code | output | 32 | Most recently pushed code |
| last_time | output | 32 | Most recently pushed timestamp |
| last_valid | output | 1 | Most recent code is a real error |

## Verification
A wrap flag that is lost, duplicated, or moved by the wrong amount shows up on the read port at once. The next full sweep of logical indices returns entries rotated out of age order, or empty entries where history should be. This becomes visible one cycle after the first read following the push that caused it. A storage slot written at the wrong address shows up on `last_code` in the cycle right after that push. The directed sweeps compare all 32 logical indices against a history kept in the bench, both before and after the ring wraps.

// File: rtl/elog_pkg.sv
// Shared widths and entry type for the circular error log.
// Assumes code and time fields are fixed for the whole log.
package elog_pkg;
    parameter int ELOG_CODE_W = 32;
    parameter int ELOG_TIME_W = 32;

    typedef struct packed {
        logic [ELOG_CODE_W-1:0] code;
        logic [ELOG_TIME_W-1:0] stamp;
    } elog_entry_t;

    localparam elog_entry_t ELOG_EMPTY = '{code: '1, stamp: '1};
endpackage

// File: rtl/elog_marker_ring.sv
// Wrap-flag ring: one flag bit per slot, exactly one set, marking the
// next slot to be written (the oldest entry once full). Encodes the flag
// position and the slot of the newest entry. Assumes DEPTH is a power of two.
module elog_marker_ring #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [DEPTH-1:0] flags,
    output logic [IDX_W-1:0] mark_pos,
    output logic [IDX_W-1:0] newest_pos
);
    // Flag register: set at slot 0 on reset, rotate up by one per push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= {{(DEPTH-1){1'b0}}, 1'b1};
        end else if (advance) begin
            flags <= {flags[DEPTH-2:0], flags[DEPTH-1]};
        end
    end

    // Encoder: OR together the indices of set flags (one-hot input).
    always_comb begin
        mark_pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (flags[i]) mark_pos = mark_pos | IDX_W'(i);
        end
    end

    // Newest entry sits one slot behind the flag, modulo DEPTH.
    assign newest_pos = mark_pos - IDX_W'(1);
endmodule

// File: rtl/elog_store.sv
// Slot storage held in flops so every slot can be preset to all-ones on
// reset. One write port and two combinational read ports.
module elog_store
    import elog_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  elog_entry_t      wr_data,
    input  logic [IDX_W-1:0] ra_addr,
    output elog_entry_t      ra_data,
    input  logic [IDX_W-1:0] rb_addr,
    output elog_entry_t      rb_data
);
    elog_entry_t slots [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Slot register: preset empty on reset, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[s] <= ELOG_EMPTY;
            end else if (wr_en && (wr_addr == IDX_W'(s))) begin
                slots[s] <= wr_data;
            end
        end
    end

    // Read port A: logical-read path.
    assign ra_data = slots[ra_addr];
    // Read port B: newest-entry path.
    assign rb_data = slots[rb_addr];
endmodule

// File: rtl/elog_reader.sv
// Logical-index read: maps index to slot (flag position + index, modulo
// DEPTH), registers the entry and flags all-ones codes as not valid.
module elog_reader
    import elog_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [IDX_W-1:0]       mark_pos,
    output logic [IDX_W-1:0]       slot_addr,
    input  elog_entry_t            slot_data,
    output logic [ELOG_CODE_W-1:0] rd_code,
    output logic [ELOG_TIME_W-1:0] rd_time,
    output logic                   rd_valid
);
    // Address map: rotation by the flag position, wrapping by width.
    assign slot_addr = mark_pos + rd_idx;

    // Output register: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_code  <= '1;
            rd_time  <= '1;
            rd_valid <= 1'b0;
        end else if (rd_en) begin
            rd_code  <= slot_data.code;
            rd_time  <= slot_data.stamp;
            rd_valid <= (slot_data.code != '1);
        end
    end
endmodule

// File: rtl/elog_ring_top.sv
// Circular error log top: push port, logical read port, last-error view.
// Each push writes the flagged slot and advances the flag by one.
module elog_ring_top
    import elog_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_en,
    input  logic [ELOG_CODE_W-1:0] push_code,
    input  logic [ELOG_TIME_W-1:0] push_time,
    input  logic                   rd_en,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [ELOG_CODE_W-1:0] rd_code,
    output logic [ELOG_TIME_W-1:0] rd_time,
    output logic                   rd_valid,
    output logic [ELOG_CODE_W-1:0] last_code,
    output logic [ELOG_TIME_W-1:0] last_time,
    output logic                   last_valid
);
    logic [DEPTH-1:0] mark_flags;
    logic [IDX_W-1:0] mark_pos;
    logic [IDX_W-1:0] newest_pos;
    logic [IDX_W-1:0] rd_slot;
    elog_entry_t      rd_entry;
    elog_entry_t      newest_entry;
    elog_entry_t      push_entry;

    // Pack the incoming event.
    assign push_entry = '{code: push_code, stamp: push_time};

    elog_marker_ring #(.DEPTH(DEPTH)) u_marker (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (push_en),
        .flags      (mark_flags),
        .mark_pos   (mark_pos),
        .newest_pos (newest_pos)
    );

    elog_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_en),
        .wr_addr (mark_pos),
        .wr_data (push_entry),
        .ra_addr (rd_slot),
        .ra_data (rd_entry),
        .rb_addr (newest_pos),
        .rb_data (newest_entry)
    );

    elog_reader #(.DEPTH(DEPTH)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .mark_pos  (mark_pos),
        .slot_addr (rd_slot),
        .slot_data (rd_entry),
        .rd_code   (rd_code),
        .rd_time   (rd_time),
        .rd_valid  (rd_valid)
    );

    // Last-error view: newest slot, all-ones code means nothing real.
    assign last_code  = newest_entry.code;
    assign last_time  = newest_entry.stamp;
    assign last_valid = (newest_entry.code != '1);
endmodule

// File: rtl/elog_ring_checker.sv
// Assertion checker for elog_ring_top, attached by bind below.
module elog_ring_checker
    import elog_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   push_en,
    input logic [ELOG_CODE_W-1:0] push_code,
    input logic [ELOG_TIME_W-1:0] push_time,
    input logic                   rd_en,
    input logic [ELOG_CODE_W-1:0] rd_code,
    input logic [ELOG_TIME_W-1:0] rd_time,
    input logic                   rd_valid,
    input logic [ELOG_CODE_W-1:0] last_code,
    input logic [ELOG_TIME_W-1:0] last_time,
    input logic [DEPTH-1:0]       mark_flags,
    input logic [IDX_W-1:0]       mark_pos
);
    p_last_follows_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (last_code == $past(push_code)) && (last_time == $past(push_time)));

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_code) && $stable(rd_time) && $stable(rd_valid));

    p_flag_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(mark_flags));

    p_flag_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> mark_pos == $past(mark_pos) + IDX_W'(1));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !push_en |=> $stable(mark_pos) && $stable(last_code) && $stable(last_time));
endmodule

bind elog_ring_top elog_ring_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_en    (push_en),
    .push_code  (push_code),
    .push_time  (push_time),
    .rd_en      (rd_en),
    .rd_code    (rd_code),
    .rd_time    (rd_time),
    .rd_valid   (rd_valid),
    .last_code  (last_code),
    .last_time  (last_time),
    .mark_flags (mark_flags),
    .mark_pos   (mark_pos)
);

// File: tb/elog_ring_top_test.sv
// Directed bench for elog_ring_top; one task per scenario.
module elog_ring_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_en = 1'b0;
    logic [31:0] push_code = '0;
    logic [31:0] push_time = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_code, rd_time, last_code, last_time;
    logic        rd_valid, last_valid;

    int checks = 0;
    int failures = 0;

    logic [31:0] h_code [256];
    logic [31:0] h_time [256];
    int          n_push = 0;

    always #2.5 clk = ~clk;

    elog_ring_top uut (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_code(push_code),
        .push_time(push_time), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_code(rd_code), .rd_time(rd_time), .rd_valid(rd_valid),
        .last_code(last_code), .last_time(last_time), .last_valid(last_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [31:0] c, input logic [31:0] t);
        @(negedge clk);
        push_en = 1'b1; push_code = c; push_time = t;
        @(negedge clk);
        push_en = 1'b0;
        h_code[n_push] = c; h_time[n_push] = t; n_push++;
    endtask

    task automatic do_read(input int idx);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 5'(idx);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Expected entry for a logical index, from the push history.
    task automatic expect_idx(input int idx, output logic [31:0] c, output logic [31:0] t, output logic v);
        int k = n_push - 32 + idx;
        if (k < 0) begin c = '1; t = '1; end
        else begin c = h_code[k]; t = h_time[k]; end
        v = (c != 32'hFFFF_FFFF);
    endtask

    task automatic sweep(input string req);
        logic [31:0] ec, et;
        logic ev;
        for (int i = 0; i < 32; i++) begin
            do_read(i);
            expect_idx(i, ec, et, ev);
            chk(rd_code == ec && rd_time == et && rd_valid == ev, req,
                {rd_code, rd_time}, {ec, et});
        end
    endtask

    task automatic t_reset();
        chk(last_valid == 1'b0, "R1 last_valid", 64'(last_valid), 64'd0);
        sweep("R1/R5 empty sweep");
    endtask

    task automatic t_partial();
        for (int k = 0; k < 5; k++) begin
            do_push(32'hA040_3000 + 32'(k), 32'h0B56_0000 + 32'(k));
            chk(last_code == h_code[k] && last_time == h_time[k] && last_valid,
                "R2 last after push", {last_code, last_time}, {h_code[k], h_time[k]});
        end
        sweep("R3/R5 partial order");
    endtask

    task automatic t_wrap();
        for (int k = 0; k < 35; k++)
            do_push(32'hA090_2100 + 32'(k), 32'h1000_0000 + 32'(k * 7));
        sweep("R4/R9 wrapped order");
    endtask

    task automatic t_allones();
        do_push(32'hFFFF_FFFF, 32'h0000_1234);
        chk(last_valid == 1'b0 && last_time == 32'h0000_1234, "R8 last all-ones",
            {31'd0, last_valid, last_time}, 64'h0000_1234);
        do_read(31);
        chk(rd_valid == 1'b0 && rd_code == '1, "R8 read all-ones",
            64'(rd_valid), 64'd0);
        do_push(32'hA021_3013, 32'h0000_2000);
    endtask

    task automatic t_hold();
        logic [31:0] c0, t0, lc;
        do_read(3);
        c0 = rd_code; t0 = rd_time; lc = last_code;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rd_idx = 5'(k + 10);
        end
        chk(rd_code == c0 && rd_time == t0, "R6 hold read", {rd_code, rd_time}, {c0, t0});
        chk(last_code == lc, "R10 idle last", 64'(last_code), 64'(lc));
        sweep("R10 idle order");
    endtask

    task automatic t_same_cycle();
        logic [31:0] prev_c, prev_t;
        prev_c = h_code[n_push-1]; prev_t = h_time[n_push-1];
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 5'd31;
        push_en = 1'b1; push_code = 32'hA020_2120; push_time = 32'h0000_3000;
        @(negedge clk);
        rd_en = 1'b0; push_en = 1'b0;
        h_code[n_push] = 32'hA020_2120; h_time[n_push] = 32'h0000_3000; n_push++;
        chk(rd_code == prev_c && rd_time == prev_t, "R7 read before push",
            {rd_code, rd_time}, {prev_c, prev_t});
        chk(last_code == 32'hA020_2120, "R7 push landed", 64'(last_code), 64'hA020_2120);
        sweep("R4 after concurrent push");
    endtask

    initial begin
        #200000;
        checks++; failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_partial();
        t_wrap();
        t_allones();
        t_hold();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule